// File: doc/BRIEF.md
# D-Channel Access Arbiter

This block decides when a terminal may place its own data on a shared, bit-serial signalling channel of a basic-rate subscriber bus. Several terminals share the upstream channel. The network side returns every bit it receives on an echo channel, and a line that nobody drives reads as ONE. The arbiter counts consecutive echo ONEs. Once the count reaches a threshold set by the terminal's priority class and by its current level, and an upstream HDLC framer has a frame waiting, the block hands the bit slot to the framer.

While the framer sends, each echo bit is compared with the bit driven in the same position. On a mismatch the block yields the bus, reports an abort to the framer and starts counting again. After a frame ends cleanly the block moves to a raised threshold, so other terminals get a turn. It drops back to the normal threshold once it has seen enough idle ONEs with no request pending. A command input selects the priority class. A mode field turns arbitration on or off, and when it is off data passes straight through.

Top module: `dch_access_arb`

## Requirements
- R1: Arbitration is active only when `mode_i` equals 3'd1. For any other value, `d_o` follows `tx_bit_i`, `rdy_o` follows `req_i` and `abort_o` stays low. Returning to mode 1 restarts counting from zero.
- R2: In mode 1, `d_o` is ONE whenever `rdy_o` is low.
- R3: In the high class, a frame may start after 8 consecutive echo ONEs at the normal level, or after 10 at the raised level.
- R4: In the low class, a frame may start after 10 consecutive echo ONEs at the normal level, or after 11 at the raised level.
- R5: A command with `cmd_vld_i` high and `cmd_i` = 4'h8 selects the high class. Code 4'h9 selects the low class. All other codes are ignored. A class change keeps the current level and applies from the next counted bit.
- R6: An echo ZERO on a counted bit clears the consecutive-ONE count.
- R7: `rdy_o` goes high after the strobe on which the count, including that bit, reaches the threshold while `req_i` is high. While `rdy_o` is high, `d_o` equals `tx_bit_i`.
- R8: On a strobe with `rdy_o` high and `echo_i` different from `d_o`, `rdy_o` falls and `abort_o` pulses for one clock. Counting restarts from zero and the level is kept. If `eof_i` is high on that same strobe, the collision takes precedence.
- R9: A strobe with `rdy_o` high, `eof_i` high and matching echo ends the frame: `rdy_o` falls, no abort is raised, and the level becomes raised.
- R10: At the raised level, once the count reaches the raised threshold with `req_i` low, the level returns to normal.
- R11: After reset the block is in the high class at the normal level, with `rdy_o` and `abort_o` low and `d_o` at ONE in mode 1.
- R12: In mode 1, `rdy_o` changes only in the clock that follows a bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode field; 1 enables arbitration |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Activation-request code selecting the priority class |
| bit_stb_i | input | 1 | One-clock strobe per bus bit |
| echo_i | input | 1 | Echo bit returned by the network side |
| tx_bit_i | input | 1 | Data bit from the framer |
| req_i | input | 1 | Framer has a frame pending |
| eof_i | input | 1 | Current bit is the last of the frame |
| d_o | output | 1 | Bit driven on the upstream channel |
| rdy_o | output | 1 | Framer owns the channel |
| abort_o | output | 1 | One-clock collision pulse to the framer |

## Verification
A collision and the end of a frame can both happen on the same bit strobe. The bench provokes this by raising `eof_i` on a bit whose echo differs from the sent bit. It judges the result in two ways. First, `abort_o` must pulse. Second, the next access must still need only the normal threshold of 8 ONEs, which shows that the level was not raised. The bench also changes the priority class between frames and checks that an unknown command code leaves the threshold unchanged.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;
  localparam int unsigned CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_AR_HI = 4'h8;
  localparam logic [CMD_W-1:0] CMD_AR_LO = 4'h9;
  localparam logic [2:0] MODE_ARB = 3'd1;

  typedef enum logic {CLS_HI = 1'b0, CLS_LO = 1'b1} cls_e;
  typedef enum logic {LVL_NORM = 1'b0, LVL_RAISED = 1'b1} lvl_e;
  typedef enum logic {ST_COUNT = 1'b0, ST_SEND = 1'b1} st_e;
endpackage

// File: rtl/dch_class_reg.sv
module dch_class_reg
  import dch_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_i,
  output cls_e             cls_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_o <= CLS_HI;
    end else if (cmd_vld_i) begin
      if (cmd_i == CMD_AR_HI)      cls_o <= CLS_HI;
      else if (cmd_i == CMD_AR_LO) cls_o <= CLS_LO;
    end
  end
endmodule

// File: rtl/dch_thr_sel.sv
module dch_thr_sel
  import dch_arb_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned HI_NORM   = 8,
  parameter int unsigned HI_RAISED = 10,
  parameter int unsigned LO_NORM   = 10,
  parameter int unsigned LO_RAISED = 11
) (
  input  cls_e             cls_i,
  input  lvl_e             lvl_i,
  output logic [CNT_W-1:0] thr_o
);
  logic [CNT_W-1:0] thr_tab [4];

  // index = {class, level}
  assign thr_tab[0] = CNT_W'(HI_NORM);
  assign thr_tab[1] = CNT_W'(HI_RAISED);
  assign thr_tab[2] = CNT_W'(LO_NORM);
  assign thr_tab[3] = CNT_W'(LO_RAISED);

  assign thr_o = thr_tab[{cls_i, lvl_i}];
endmodule

// File: rtl/dch_ones_cnt.sv
module dch_ones_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             echo_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // saturating count of consecutive ONEs, including the current bit
  always_comb begin
    if (!echo_i)               cnt_nxt_o = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt_o = cnt_q;
    else                       cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/dch_tx_fsm.sv
module dch_tx_fsm
  import dch_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arb_i,
  input  logic             bit_stb_i,
  input  logic             echo_i,
  input  logic             tx_bit_i,
  input  logic             req_i,
  input  logic             eof_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             step_o,
  output logic             clr_o,
  output lvl_e             lvl_o,
  output logic             send_o,
  output logic             abort_o
);
  st_e  st_q;
  logic thr_hit, grant, collide;

  assign thr_hit = cnt_nxt_i >= thr_i;
  assign grant   = arb_i && bit_stb_i && (st_q == ST_COUNT) && thr_hit && req_i;
  assign collide = arb_i && bit_stb_i && (st_q == ST_SEND) && (echo_i != tx_bit_i);

  assign step_o = arb_i && bit_stb_i && (st_q == ST_COUNT);
  assign clr_o  = !arb_i || grant || (bit_stb_i && st_q == ST_SEND);
  assign send_o = st_q == ST_SEND;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_COUNT;
      lvl_o   <= LVL_NORM;
      abort_o <= 1'b0;
    end else if (!arb_i) begin
      st_q    <= ST_COUNT;
      abort_o <= 1'b0;
    end else begin
      abort_o <= 1'b0;
      if (bit_stb_i) begin
        unique case (st_q)
          ST_COUNT: begin
            if (grant) st_q <= ST_SEND;
            else if (thr_hit && lvl_o == LVL_RAISED) lvl_o <= LVL_NORM;
          end
          ST_SEND: begin
            if (collide) begin
              st_q    <= ST_COUNT;
              abort_o <= 1'b1;
            end else if (eof_i) begin
              st_q  <= ST_COUNT;
              lvl_o <= LVL_RAISED;
            end
          end
          default: st_q <= ST_COUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/dch_access_arb.sv
module dch_access_arb
  import dch_arb_pkg::*;
#(
  parameter int unsigned HI_NORM   = 8,
  parameter int unsigned HI_RAISED = 10,
  parameter int unsigned LO_NORM   = 10,
  parameter int unsigned LO_RAISED = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             bit_stb_i,
  input  logic             echo_i,
  input  logic             tx_bit_i,
  input  logic             req_i,
  input  logic             eof_i,
  output logic             d_o,
  output logic             rdy_o,
  output logic             abort_o
);
  localparam int unsigned MAX_HI  = (HI_NORM > HI_RAISED) ? HI_NORM : HI_RAISED;
  localparam int unsigned MAX_LO  = (LO_NORM > LO_RAISED) ? LO_NORM : LO_RAISED;
  localparam int unsigned MAX_THR = (MAX_HI > MAX_LO) ? MAX_HI : MAX_LO;
  localparam int unsigned CNT_W   = $clog2(MAX_THR + 1);

  logic             arb;
  cls_e             cls;
  lvl_e             lvl;
  logic [CNT_W-1:0] thr, cnt_nxt;
  logic             step, clr, send;

  assign arb = mode_i == MODE_ARB;

  dch_class_reg u_cls (
    .clk_i, .rst_ni, .cmd_vld_i, .cmd_i, .cls_o(cls)
  );

  dch_thr_sel #(
    .CNT_W(CNT_W), .HI_NORM(HI_NORM), .HI_RAISED(HI_RAISED),
    .LO_NORM(LO_NORM), .LO_RAISED(LO_RAISED)
  ) u_thr (
    .cls_i(cls), .lvl_i(lvl), .thr_o(thr)
  );

  dch_ones_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step), .echo_i, .cnt_nxt_o(cnt_nxt)
  );

  dch_tx_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .arb_i(arb), .bit_stb_i, .echo_i, .tx_bit_i, .req_i, .eof_i,
    .cnt_nxt_i(cnt_nxt), .thr_i(thr), .step_o(step), .clr_o(clr),
    .lvl_o(lvl), .send_o(send), .abort_o
  );

  // idle terminal drives ONE so it never masks others
  assign d_o   = arb ? (send ? tx_bit_i : 1'b1) : tx_bit_i;
  assign rdy_o = arb ? send : req_i;
endmodule

// File: rtl/dch_arb_chk.sv
module dch_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       bit_stb_i,
  input logic       echo_i,
  input logic       tx_bit_i,
  input logic       req_i,
  input logic       d_o,
  input logic       rdy_o,
  input logic       abort_o
);
  assert_pass_through_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 3'd1 |-> d_o == tx_bit_i);

  assert_idle_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && !rdy_o) |-> d_o);

  assert_grant_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && $past(mode_i) == 3'd1 && $rose(rdy_o)) |-> ($past(bit_stb_i) && $past(req_i)));

  assert_collision_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && bit_stb_i && rdy_o && echo_i != d_o) |=> (abort_o && (mode_i != 3'd1 || !rdy_o)));

  assert_abort_no_rdy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_o && mode_i == 3'd1) |-> !rdy_o);

  assert_strobe_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && $past(mode_i) == 3'd1 && !$past(bit_stb_i)) |-> $stable(rdy_o));
endmodule

bind dch_access_arb dch_arb_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .bit_stb_i(bit_stb_i),
  .echo_i(echo_i), .tx_bit_i(tx_bit_i), .req_i(req_i), .d_o(d_o),
  .rdy_o(rdy_o), .abort_o(abort_o)
);

// File: tb/sim_dch_access_arb.sv
`timescale 1ns/1ps
module sim_dch_access_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic       cmd_vld_i = 1'b0;
  logic [3:0] cmd_i = 4'h0;
  logic       bit_stb_i = 1'b0, echo_i = 1'b1, tx_bit_i = 1'b0;
  logic       req_i = 1'b0, eof_i = 1'b0;
  logic       d_o, rdy_o, abort_o;

  dch_access_arb u0 (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic  d;
    logic  rdy;
    logic  abort;
    string tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic bit_t(input logic e, input logic tx, input logic rq, input logic eof,
                       input logic xd, input logic xr, input logic xa, input string tag);
    item_t it;
    it.d = xd; it.rdy = xr; it.abort = xa; it.tag = tag;
    @(negedge clk_i);
    echo_i = e; tx_bit_i = tx; req_i = rq; eof_i = eof; bit_stb_i = 1'b1;
    q.push_back(it);
    @(negedge clk_i);
    bit_stb_i = 1'b0; eof_i = 1'b0;
  endtask

  // n idle ONEs; rdy expected only after the last one when last_rdy
  task automatic ones(input int n, input logic rq, input logic last_rdy, input string tag);
    for (int i = 0; i < n; i++)
      bit_t(1'b1, 1'b0, rq, 1'b0, 1'b1, (i == n - 1) ? last_rdy : 1'b0, 1'b0, tag);
  endtask

  task automatic send_cmd(input logic [3:0] c);
    @(negedge clk_i);
    cmd_vld_i = 1'b1; cmd_i = c;
    @(negedge clk_i);
    cmd_vld_i = 1'b0;
  endtask

  // monitor: d_o during the strobe, rdy/abort one clock later
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (bit_stb_i) begin
        item_t it;
        if (q.size() == 0) begin
          chk(1'b0, "R12", "unexpected strobe", 0, 1);
        end else begin
          it = q.pop_front();
          chk(d_o == it.d, it.tag, "d_o", d_o, it.d);
          @(negedge clk_i);
          #1;
          chk(rdy_o == it.rdy, it.tag, "rdy_o", rdy_o, it.rdy);
          chk(abort_o == it.abort, it.tag, "abort_o", abort_o, it.abort);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(rdy_o == 1'b0, "R11", "rdy_o after reset", rdy_o, 0);
    chk(abort_o == 1'b0, "R11", "abort_o after reset", abort_o, 0);
    chk(d_o == 1'b1, "R11", "d_o after reset", d_o, 1);

    // high class, normal level: 8 ONEs
    ones(8, 1'b1, 1'b1, "R3");
    // collision: sent 0, echo 1
    bit_t(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    // level kept normal after collision
    ones(8, 1'b1, 1'b1, "R8");
    // collision and end of frame on the same bit: collision wins
    bit_t(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    ones(8, 1'b1, 1'b1, "R8");
    bit_t(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    bit_t(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    bit_t(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    // raised level of high class: 10
    ones(10, 1'b1, 1'b1, "R3");
    bit_t(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
    // back to normal after 10 ONEs with no request, then zero clears count
    ones(10, 1'b0, 1'b0, "R10");
    bit_t(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    ones(8, 1'b1, 1'b1, "R10");
    bit_t(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    // low class, unknown code ignored
    send_cmd(4'h9);
    send_cmd(4'h0);
    ones(11, 1'b0, 1'b0, "R4");
    bit_t(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    ones(10, 1'b1, 1'b1, "R4");
    bit_t(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    ones(11, 1'b1, 1'b1, "R4");
    bit_t(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    // back to high class, raised level kept: 10
    send_cmd(4'h8);
    bit_t(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    ones(10, 1'b1, 1'b1, "R5");
    bit_t(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    // pass-through mode
    @(negedge clk_i);
    mode_i = 3'd0;
    bit_t(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R1");
    bit_t(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    @(negedge clk_i);
    mode_i = 3'd1;
    ones(1, 1'b1, 1'b0, "R1");
    bit_t(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");

    repeat (4) @(negedge clk_i);
    chk(q.size() == 0, "R12", "pending items", q.size(), 0);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule